// File: doc/BRIEF.md
# Linear Delta Modulation Encoder

This block converts a stream of unsigned samples into a one-bit-per-sample delta code. It holds a running estimate of the signal. For every accepted sample it compares the sample against that estimate and emits a direction bit. A 1 means the sample lay above the estimate, so the estimate climbs by a fixed step. A 0 means it did not, so the estimate falls by the same step. Both moves saturate at the ends of the sample range.

The step size comes from a configuration input. The block captures that input only on cycles with no incoming sample, so the step stays fixed across a burst. Each accepted sample yields exactly one output bit with its own valid strobe, one clock later. The current estimate is also driven out so a decoder model or a debug probe can follow it.

Top module: `dm_linear_encoder`

## Requirements
- R1: A synchronous active-high reset sets the estimate to midscale (2048 for 12-bit samples), deasserts `bit_valid` and loads a step of 32.
- R2: When a sample is strictly greater than the estimate held before that cycle, the emitted bit is 1 and the estimate rises by the step.
- R3: When a sample is less than or equal to the held estimate, the bit is 0 and the estimate falls by the step. An exact tie gives 0.
- R4: On a fall, if the estimate is smaller than the step, the estimate becomes 0 instead of wrapping.
- R5: On a rise, if estimate plus step exceeds 4095, the estimate becomes 4095 instead of wrapping.
- R6: The step register loads `step_cfg` only on clock edges where `smp_valid` is low. A value presented together with a sample has no effect on that sample or on any later one until an idle cycle.
- R7: Each cycle with `smp_valid` high yields exactly one `bit_valid` pulse at the next edge. No pulse appears otherwise.
- R8: `est_dbg` shows the estimate after the latest update and holds its value across idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Unsigned input sample |
| step_cfg | input | 12 | Step size, captured on idle cycles |
| bit_valid | output | 1 | Strobe for the encoded bit |
| bit_out | output | 1 | Encoded direction bit |
| est_dbg | output | 12 | Current running estimate |

## Verification
Every result is due one clock after the edge that accepts the sample. `bit_out`, `bit_valid` and the updated `est_dbg` all change at that same edge. A step written on an idle cycle applies from the next sample onward. The bench drives on falling edges and computes each expected bit and estimate at the accepting rising edge. It queues those values, and a monitor compares them on the following falling edge whenever `bit_valid` is high. Any strobe with an empty queue, and any entry left over at the end, counts as a failure. Idle-hold and reset values are read a fraction of a cycle after the edge that sets them.

// File: rtl/dm_enc_pkg.sv
package dm_enc_pkg;

    localparam int unsigned SMP_W     = 12;
    localparam int unsigned STEP_INIT = 32;

    typedef enum logic {
        SLOPE_DOWN = 1'b0,
        SLOPE_UP   = 1'b1
    } slope_e;

    function automatic logic [SMP_W-1:0] midscale_of();
        return {1'b1, {(SMP_W-1){1'b0}}};
    endfunction

    function automatic logic [SMP_W-1:0] fullscale_of();
        return {SMP_W{1'b1}};
    endfunction

endpackage

// File: rtl/dm_step_hold.sv
module dm_step_hold #(
    parameter int unsigned W         = dm_enc_pkg::SMP_W,
    parameter int unsigned RESET_VAL = dm_enc_pkg::STEP_INIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         busy,
    input  logic [W-1:0] step_in,
    output logic [W-1:0] step_q
);
    localparam logic [W-1:0] INIT = W'(RESET_VAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= INIT;
        end else if (!busy) begin
            step_q <= step_in;
        end
    end
endmodule

// File: rtl/dm_slope_decide.sv
module dm_slope_decide #(
    parameter int unsigned W = dm_enc_pkg::SMP_W
) (
    input  logic [W-1:0]       est,
    input  logic [W-1:0]       sample,
    input  logic [W-1:0]       step,
    output dm_enc_pkg::slope_e dir,
    output logic [W-1:0]       est_next
);
    import dm_enc_pkg::*;

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W:0]   up_sum;
    logic [W-1:0] up_val;
    logic [W-1:0] dn_val;

    always_comb begin
        up_sum = {1'b0, est} + {1'b0, step};
        up_val = up_sum[W] ? TOP : up_sum[W-1:0];
        dn_val = (est < step) ? '0 : (est - step);
        dir    = (sample > est) ? SLOPE_UP : SLOPE_DOWN;
        est_next = (dir == SLOPE_UP) ? up_val : dn_val;
    end
endmodule

// File: rtl/dm_est_track.sv
module dm_est_track #(
    parameter int unsigned W = dm_enc_pkg::SMP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  dm_enc_pkg::slope_e dir,
    input  logic [W-1:0]       est_next,
    output logic [W-1:0]       est_q,
    output logic               bit_q,
    output logic               vld_q
);
    import dm_enc_pkg::*;

    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            est_q <= MID;
            bit_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= take;
            if (take) begin
                est_q <= est_next;
                bit_q <= (dir == SLOPE_UP);
            end
        end
    end
endmodule

// File: rtl/dm_linear_encoder.sv
module dm_linear_encoder #(
    parameter int unsigned W         = dm_enc_pkg::SMP_W,
    parameter int unsigned STEP_INIT = dm_enc_pkg::STEP_INIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    input  logic [W-1:0] step_cfg,
    output logic         bit_valid,
    output logic         bit_out,
    output logic [W-1:0] est_dbg
);
    import dm_enc_pkg::*;

    logic [W-1:0] step_q;
    logic [W-1:0] est_q;
    logic [W-1:0] est_next;
    slope_e       dir;

    dm_step_hold #(.W(W), .RESET_VAL(STEP_INIT)) u_step (
        .clk     (clk),
        .rst     (rst),
        .busy    (smp_valid),
        .step_in (step_cfg),
        .step_q  (step_q)
    );

    dm_slope_decide #(.W(W)) u_decide (
        .est      (est_q),
        .sample   (smp_data),
        .step     (step_q),
        .dir      (dir),
        .est_next (est_next)
    );

    dm_est_track #(.W(W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .take     (smp_valid),
        .dir      (dir),
        .est_next (est_next),
        .est_q    (est_q),
        .bit_q    (bit_out),
        .vld_q    (bit_valid)
    );

    assign est_dbg = est_q;
endmodule

// File: rtl/dm_linear_encoder_chk.sv
module dm_linear_encoder_chk #(
    parameter int unsigned W = dm_enc_pkg::SMP_W
) (
    input logic         clk,
    input logic         rst,
    input logic         smp_valid,
    input logic [W-1:0] smp_data,
    input logic         bit_valid,
    input logic         bit_out,
    input logic [W-1:0] est_dbg
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (est_dbg == MID) && !bit_valid);

    // R7
    one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> bit_valid);

    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !bit_valid);

    // R2
    above_gives_one_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && (smp_data > est_dbg)) |=> bit_out && (est_dbg >= $past(est_dbg)));

    // R3
    tie_or_below_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && (smp_data <= est_dbg)) |=> !bit_out && (est_dbg <= $past(est_dbg)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(est_dbg));
endmodule

bind dm_linear_encoder dm_linear_encoder_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .bit_valid (bit_valid),
    .bit_out   (bit_out),
    .est_dbg   (est_dbg)
);

// File: tb/dm_linear_encoder_test.sv
`timescale 1ns/1ps
module dm_linear_encoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic [11:0] step_cfg = 12'd32;
    logic        bit_valid;
    logic        bit_out;
    logic [11:0] est_dbg;

    typedef struct {
        logic        b;
        logic [11:0] e;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    int   m_est  = 2048;
    int   m_step = 32;
    bit   done   = 1'b0;

    always #2.5 clk = ~clk;

    dm_linear_encoder uut (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .step_cfg  (step_cfg),
        .bit_valid (bit_valid),
        .bit_out   (bit_out),
        .est_dbg   (est_dbg)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (bit_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7", "strobe without sample", 1, 0);
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    chk(bit_out == x.b, x.tag, "bit", int'(bit_out), int'(x.b));
                    chk(int'(est_dbg) == int'(x.e), x.tag, "estimate", int'(est_dbg), int'(x.e));
                end
            end
        end
    end

    task automatic send(input int sample, input int step, input string tag);
        exp_t x;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 12'(sample);
        step_cfg  = 12'(step);
        @(posedge clk);
        x.b = (sample > m_est);
        if (x.b) m_est = (m_est + m_step > 4095) ? 4095 : m_est + m_step;
        else     m_est = (m_est < m_step) ? 0 : m_est - m_step;
        x.e   = 12'(m_est);
        x.tag = tag;
        q.push_back(x);
    endtask

    task automatic idle(input int n, input int step);
        @(negedge clk);
        smp_valid = 1'b0;
        step_cfg  = 12'(step);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            m_step = step;
            #1;
            chk(!bit_valid || (i == 0), "R7", "valid while idle", int'(bit_valid), 0);
            if (i > 0) chk(int'(est_dbg) == m_est, "R8", "held estimate", int'(est_dbg), m_est);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        step_cfg = 12'd500;
        @(posedge clk);
        #1;
        chk(int'(est_dbg) == 2048, "R1", "reset estimate", int'(est_dbg), 2048);
        chk(bit_valid == 1'b0, "R1", "reset valid", int'(bit_valid), 0);
        q.delete();
        m_est  = 2048;
        m_step = 32;
        @(negedge clk);
        // hold reset one more edge, then release with a sample so the reset step is used
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        smp_valid = 1'b1;
        smp_data  = 12'd4000;
        @(posedge clk);
        m_est = 2048 + 32;
        begin
            exp_t x;
            x.b = 1'b1; x.e = 12'(m_est); x.tag = "R1";
            q.push_back(x);
        end
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "WATCHDOG", "timeout", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R2: rising run with default step
        send(3000, 32, "R2");
        send(3000, 32, "R2");
        send(3000, 32, "R2");
        // R3: exact tie then a low sample
        send(m_est, 32, "R3");
        send(100, 32, "R3");
        // R8 and R6: idle loads a new step of 1000
        idle(3, 1000);
        // R4: fall saturates at zero
        send(0, 1000, "R4");
        send(0, 1000, "R4");
        send(0, 1000, "R4");
        send(0, 1000, "R4");
        // R5: rise saturates at full scale
        send(4095, 1000, "R5");
        send(4095, 1000, "R5");
        send(4095, 1000, "R5");
        send(4095, 1000, "R5");
        send(4095, 1000, "R5");
        // R6: step presented with samples is ignored
        send(0, 5, "R6");
        send(0, 7, "R6");
        idle(2, 5);
        send(0, 5, "R6");
        send(4095, 5, "R6");
        // R7: alternating back-to-back samples, one bit each
        for (int k = 0; k < 8; k++) send((k % 2) ? 0 : 4095, 5, "R7");
        idle(2, 5);
        // R1: reset in mid-stream
        send(4095, 5, "R2");
        do_reset();
        send(0, 32, "R3");
        idle(2, 32);
        chk(q.size() == 0, "R7", "outstanding results", q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule